// File: doc/BRIEF.md
# Branch target and direction predictor

This block sits beside the fetch address register and guesses where fetch goes next. Each cycle the fetch PC is searched at the same time in two structures. One is a small fully associative target cache that holds only branches known to go taken, with their destinations. The other is a larger direct-indexed table of 2-bit saturating counters that gives a taken or not-taken direction. A target-cache hit gives the stored destination as the next fetch address. A miss gives the sequential address. The direction bit is reported on its own port, so that decode can use it.

Both structures are trained only when a branch resolves. A resolve port carries the branch PC, whether it went taken and where it went. A taken branch that is not yet cached gets a slot chosen round-robin. A taken branch that is cached gets its destination refreshed. A not-taken branch that is cached loses its slot. The counter selected by the branch PC moves one step towards the outcome. Lookup is purely combinational and reads the state held at the start of the cycle. An update therefore becomes visible to lookups from the next cycle on.

Top module: `branch_predictor`

## Requirements
- R1: After a synchronous active-low reset every target-cache slot is empty. Every direction counter holds 01 (weakly not-taken), so any lookup then reports hit 0 and direction 0.
- R2: When the fetch PC equals the full PC stored in a valid target-cache slot, hit is 1 and next PC is that slot's stored target, in the same cycle.
- R3: When no valid slot matches the fetch PC, hit is 0 and next PC is the fetch PC plus 4.
- R4: The direction output is bit 1 of the counter selected by fetch PC bits [10:2] (1 means taken).
- R5: On a resolve, the counter selected by the branch PC bits [10:2] counts up by one if taken and down by one if not taken. It saturates at 11 and at 00.
- R6: A resolved taken branch that misses the target cache is written into the slot under a round-robin pointer. The pointer then advances by one and wraps from 63 to 0, so the 65th new taken branch replaces the first.
- R7: A resolved taken branch that hits the target cache overwrites that slot's target and allocates no new slot.
- R8: A resolved not-taken branch that hits the target cache invalidates that slot. A resolved not-taken branch that misses leaves the cache unchanged.
- R9: Updates take effect at the next clock edge. A lookup in the same cycle as an update of the same branch returns the state from before the update.
- R10: While the resolve valid input is low, neither the target cache, the round-robin pointer nor any counter changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_pc | input | 32 | Address being fetched this cycle |
| pred_hit | output | 1 | Fetch PC found in the target cache |
| pred_next_pc | output | 32 | Predicted next fetch address |
| pred_taken | output | 1 | Direction from the counter table |
| upd_valid | input | 1 | A resolved branch is presented |
| upd_pc | input | 32 | PC of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 for taken |
| upd_target | input | 32 | Resolved target address |

## Verification
The three lookup results are combinational, so they are due in the same cycle as the fetch PC. The bench drives each cycle's inputs on the falling edge and samples 1 ns later, well before the next rising edge. Resolve updates are due one rising edge after they are presented. The bench applies them to its reference model only after that cycle's comparison. This makes same-cycle lookups of an updated branch compare against the old state and later lookups against the new state. Directed sequences cover saturation at both ends, refresh, invalidation, ignored updates and pointer wrap. Seeded random traffic over a small PC pool mixes all of these.

// File: rtl/bp_pkg.sv
// Package: shared constants and counter arithmetic for the branch predictor.
// Assumes 2-bit direction counters, with bit 1 meaning "taken".
package bp_pkg;

    localparam logic [1:0] CTR_RESET = 2'b01;
    localparam logic [1:0] CTR_MAX   = 2'b11;
    localparam logic [1:0] CTR_MIN   = 2'b00;

    // Next value of a saturating 2-bit counter given a resolved outcome.
    function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic taken);
        if (taken)
            return (cur == CTR_MAX) ? cur : cur + 2'd1;
        else
            return (cur == CTR_MIN) ? cur : cur - 2'd1;
    endfunction

endpackage

// File: rtl/bp_tag_match.sv
// Module: bp_tag_match
// Compares one key against every tag of a fully associative array and
// returns a hit flag and the encoded index of the matching slot.
// Assumes that at most one valid slot matches. The owner guarantees this
// by never allocating a key that already hits.
module bp_tag_match #(
    parameter int N     = 64,
    parameter int TAG_W = 32,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]       valid,
    input  logic [N*TAG_W-1:0] tags_flat,
    input  logic [TAG_W-1:0]   key,
    output logic               hit,
    output logic [IDX_W-1:0]   idx,
    output logic [N-1:0]       match
);

    // One comparator per slot.
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = valid[g] && (tags_flat[g*TAG_W +: TAG_W] == key);
    end

    // Encode the (one-hot) match vector into an index.
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            idx = idx | (IDX_W'(i) & {IDX_W{match[i]}});
        end
    end

    assign hit = |match;

endmodule

// File: rtl/bp_target_cache.sv
// Module: bp_target_cache
// Fully associative cache of taken-branch targets. It has a combinational
// lookup port and a resolve port that is written at the clock edge.
// Slots are allocated round-robin on taken misses, refreshed on taken hits
// and invalidated on not-taken hits. The full PC is used as the tag.
// Assumes the lookup reads the state held before any same-cycle update.
module bp_target_cache #(
    parameter int ENTRIES = 64,
    parameter int PC_W    = 32,
    localparam int PTR_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_hit,
    output logic [PC_W-1:0] lk_target,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic            up_taken,
    input  logic [PC_W-1:0] up_target
);

    logic [ENTRIES-1:0]      valid_q;
    logic [PC_W-1:0]         tag_q [ENTRIES];
    logic [PC_W-1:0]         tgt_q [ENTRIES];
    logic [PTR_W-1:0]        rr_q;
    logic [ENTRIES*PC_W-1:0] tags_flat;
    logic [PTR_W-1:0]        lk_idx;
    logic [PTR_W-1:0]        up_idx;
    logic                    up_hit;
    logic [ENTRIES-1:0]      lk_match;
    logic [ENTRIES-1:0]      up_match;
    logic                    do_alloc;
    logic                    do_refresh;
    logic                    do_inval;
    logic [PTR_W-1:0]        rr_next;

    // Flatten the tags for the two matchers.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_flat
        assign tags_flat[g*PC_W +: PC_W] = tag_q[g];
    end

    bp_tag_match #(.N(ENTRIES), .TAG_W(PC_W)) u_lk_match (
        .valid(valid_q), .tags_flat(tags_flat), .key(lk_pc),
        .hit(lk_hit), .idx(lk_idx), .match(lk_match)
    );

    bp_tag_match #(.N(ENTRIES), .TAG_W(PC_W)) u_up_match (
        .valid(valid_q), .tags_flat(tags_flat), .key(up_pc),
        .hit(up_hit), .idx(up_idx), .match(up_match)
    );

    // Lookup data path: the target of the matching slot.
    assign lk_target = tgt_q[lk_idx];

    // Decode the resolve action and the wrapped round-robin successor.
    always_comb begin
        do_alloc   = up_valid &&  up_taken && !up_hit;
        do_refresh = up_valid &&  up_taken &&  up_hit;
        do_inval   = up_valid && !up_taken &&  up_hit;
        rr_next    = (rr_q == PTR_W'(ENTRIES - 1)) ? '0 : rr_q + PTR_W'(1);
    end

    // Valid bits and replacement pointer, with reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            rr_q    <= '0;
        end else if (do_alloc) begin
            valid_q[rr_q] <= 1'b1;
            rr_q          <= rr_next;
        end else if (do_inval) begin
            valid_q[up_idx] <= 1'b0;
        end
    end

    // Tag and target storage; gated by valid, so no reset is needed.
    always_ff @(posedge clk) begin
        if (do_alloc) begin
            tag_q[rr_q] <= up_pc;
            tgt_q[rr_q] <= up_target;
        end else if (do_refresh) begin
            tgt_q[up_idx] <= up_target;
        end
    end

    // Checker state: last resolve index and pointer, for the properties below.
    logic [PTR_W-1:0] chk_idx_q;
    logic [PTR_W-1:0] chk_rr_q;
    always_ff @(posedge clk) begin
        chk_idx_q <= up_idx;
        chk_rr_q  <= rr_q;
    end

    // R2
    tag_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match) && $onehot0(up_match));

    // R6
    alloc_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_taken && !up_hit) |=> valid_q[chk_rr_q] && (rr_q != chk_rr_q));

    // R7
    refresh_keeps_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_taken && up_hit) |=> $stable(rr_q) && valid_q[chk_idx_q]);

    // R8
    inval_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !up_taken && up_hit) |=> !valid_q[chk_idx_q] && $stable(rr_q));

    // R10
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !up_valid |=> $stable(valid_q) && $stable(rr_q));

endmodule

// File: rtl/bp_dir_table.sv
// Module: bp_dir_table
// Direct-indexed table of 2-bit saturating direction counters. The lookup
// is combinational. The counter chosen by the resolve index steps towards
// the outcome at the clock edge.
// Assumes the caller supplies already-sliced PC index bits.
module bp_dir_table #(
    parameter int ENTRIES = 512,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    output logic             lk_taken,
    input  logic             up_valid,
    input  logic [IDX_W-1:0] up_idx,
    input  logic             up_taken
);
    import bp_pkg::*;

    logic [1:0] ctr_q [ENTRIES];
    logic [1:0] up_cur;

    // One counter per entry, each with its own enable.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_ctr
        // Reset to weakly not-taken, then step on a matching resolve.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ctr_q[g] <= CTR_RESET;
            else if (up_valid && (up_idx == IDX_W'(g)))
                ctr_q[g] <= ctr_step(ctr_q[g], up_taken);
        end
    end

    // Direction is the counter's upper bit.
    assign lk_taken = ctr_q[lk_idx][1];
    assign up_cur   = ctr_q[up_idx];

    // Checker state: last resolve index.
    logic [IDX_W-1:0] chk_idx_q;
    always_ff @(posedge clk) chk_idx_q <= up_idx;

    // R5
    sat_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_taken && up_cur == CTR_MAX) |=> ctr_q[chk_idx_q] == CTR_MAX);

    // R5
    sat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !up_taken && up_cur == CTR_MIN) |=> ctr_q[chk_idx_q] == CTR_MIN);

    // R5
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_taken && up_cur == 2'b01) |=> ctr_q[chk_idx_q] == 2'b10);

endmodule

// File: rtl/branch_predictor.sv
// Module: branch_predictor (top)
// Fetch-side predictor. A fully associative taken-target cache and a
// direct-indexed 2-bit direction table are both searched with the fetch PC.
// Next PC is the cached target on a hit, otherwise PC+4. Both structures
// are trained from the resolve port only.
// Assumes word-aligned PCs; the direction index is PC[IDX_W+1:2].
module branch_predictor #(
    parameter int PC_W        = 32,
    parameter int TGT_ENTRIES = 64,
    parameter int DIR_ENTRIES = 512,
    localparam int DIR_IDX_W  = (DIR_ENTRIES > 1) ? $clog2(DIR_ENTRIES) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fetch_pc,
    output logic            pred_hit,
    output logic [PC_W-1:0] pred_next_pc,
    output logic            pred_taken,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic [PC_W-1:0] upd_target
);

    logic [PC_W-1:0] cached_target;

    bp_target_cache #(.ENTRIES(TGT_ENTRIES), .PC_W(PC_W)) u_tgt (
        .clk(clk), .rst_n(rst_n),
        .lk_pc(fetch_pc), .lk_hit(pred_hit), .lk_target(cached_target),
        .up_valid(upd_valid), .up_pc(upd_pc), .up_taken(upd_taken),
        .up_target(upd_target)
    );

    bp_dir_table #(.ENTRIES(DIR_ENTRIES)) u_dir (
        .clk(clk), .rst_n(rst_n),
        .lk_idx(fetch_pc[DIR_IDX_W+1:2]), .lk_taken(pred_taken),
        .up_valid(upd_valid), .up_idx(upd_pc[DIR_IDX_W+1:2]),
        .up_taken(upd_taken)
    );

    // Next fetch address: cached target on a hit, else the sequential word.
    assign pred_next_pc = pred_hit ? cached_target : fetch_pc + PC_W'(4);

endmodule

// File: tb/tb_branch_predictor.sv
`timescale 1ns/1ps
module tb_branch_predictor;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        pred_hit;
    logic [31:0] pred_next_pc;
    logic        pred_taken;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic [31:0] upd_target = '0;

    branch_predictor dut (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
        .pred_hit(pred_hit), .pred_next_pc(pred_next_pc), .pred_taken(pred_taken),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_target(upd_target)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference model
    bit          m_valid [64];
    logic [31:0] m_tag   [64];
    logic [31:0] m_tgt   [64];
    int          m_rr;
    logic [1:0]  m_ctr   [512];

    task automatic model_reset();
        for (int i = 0; i < 64; i++) m_valid[i] = 0;
        for (int i = 0; i < 512; i++) m_ctr[i] = 2'b01;
        m_rr = 0;
    endtask

    function automatic int model_find(logic [31:0] pc);
        for (int i = 0; i < 64; i++)
            if (m_valid[i] && m_tag[i] == pc) return i;
        return -1;
    endfunction

    task automatic model_update(logic [31:0] pc, logic tk, logic [31:0] tg);
        int s;
        int ix;
        s  = model_find(pc);
        ix = int'(pc[10:2]);
        if (tk) begin
            if (m_ctr[ix] != 2'b11) m_ctr[ix] = m_ctr[ix] + 2'd1;
            if (s >= 0) m_tgt[s] = tg;
            else begin
                m_valid[m_rr] = 1; m_tag[m_rr] = pc; m_tgt[m_rr] = tg;
                m_rr = (m_rr + 1) % 64;
            end
        end else begin
            if (m_ctr[ix] != 2'b00) m_ctr[ix] = m_ctr[ix] - 2'd1;
            if (s >= 0) m_valid[s] = 0;
        end
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One cycle: drive at falling edge, compare, then let the edge update.
    task automatic step(logic [31:0] fpc, logic uv, logic [31:0] upc,
                        logic utk, logic [31:0] utg, string req);
        int s;
        @(negedge clk);
        fetch_pc = fpc; upd_valid = uv; upd_pc = upc;
        upd_taken = utk; upd_target = utg;
        #1;
        s = model_find(fpc);
        chk({req, " hit"},  {31'd0, pred_hit}, {31'd0, s >= 0});
        chk({req, " next"}, pred_next_pc, (s >= 0) ? m_tgt[s] : fpc + 32'd4);
        chk({req, " dir"},  {31'd0, pred_taken}, {31'd0, m_ctr[fpc[10:2]][1]});
        if (uv) model_update(upc, utk, utg);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; upd_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    localparam logic [31:0] A = 32'h0000_0200;
    localparam logic [31:0] B = 32'h0000_0A40;

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        do_reset();

        // R1 reset state, hard-coded expectations
        @(negedge clk); fetch_pc = 32'h100; #1;
        chk("R1 hit",  {31'd0, pred_hit}, 32'd0);
        chk("R3 next", pred_next_pc, 32'h104);
        chk("R4 dir",  {31'd0, pred_taken}, 32'd0);

        // R9 same-cycle lookup sees old state
        step(A, 1, A, 1, 32'h8000, "R9");
        step(A, 0, 0, 0, 0, "R2 R6");          // hit 8000, ctr 10
        chk("R2 explicit", pred_next_pc, 32'h8000);
        step(A, 1, A, 1, 32'h9000, "R7");      // refresh, ctr 11
        step(A, 1, A, 1, 32'h9000, "R5 sat");  // ctr stays 11
        step(A, 1, A, 0, 0, "R5");             // ctr 10, invalidate
        step(A, 0, 0, 0, 0, "R8");
        chk("R8 explicit", {31'd0, pred_hit}, 32'd0);
        step(A, 1, A, 0, 0, "R8 miss");        // ctr 01, no cache change
        step(A, 1, A, 0, 0, "R5 dn");          // ctr 00
        step(A, 1, A, 0, 0, "R5 sat low");     // stays 00
        step(A, 1, A, 1, 32'h1234, "R5 up");   // 01, alloc
        step(A, 0, 0, 0, 0, "R5 low exit");

        // R10 ignored update
        step(B, 0, B, 1, 32'hABC0, "R10");
        step(B, 0, 0, 0, 0, "R10");
        chk("R10 explicit", {31'd0, pred_hit}, 32'd0);

        // R6 wrap: 65 distinct allocations after fresh reset
        do_reset();
        for (int i = 0; i < 65; i++)
            step(32'h4000 + 32'(i*4), 1, 32'h10000 + 32'(i*4), 1,
                 32'h20000 + 32'(i*16), "R6 fill");
        step(32'h10000, 0, 0, 0, 0, "R6 evicted");
        chk("R6 explicit evict", {31'd0, pred_hit}, 32'd0);
        step(32'h10004, 0, 0, 0, 0, "R6 kept");
        chk("R6 explicit keep", pred_next_pc, 32'h20010);

        // Constrained random mix over a small pool
        for (int c = 0; c < 4000; c++) begin
            logic [31:0] fp;
            logic [31:0] up;
            fp = 32'h3000 + 32'(($urandom % 24) * 4);
            if ($urandom % 8 == 0) fp = $urandom & 32'hFFFF_FFFC;
            up = 32'h3000 + 32'(($urandom % 24) * 4);
            if ($urandom % 4 == 0) up = fp;
            step(fp, ($urandom % 3) != 0, up, $urandom % 2,
                 $urandom & 32'hFFFF_FFFC, "R2 R3 R4 R5 R6 R7 R8 rnd");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule